// File: doc/BRIEF.md
# Burst Line-Write Bus Master

This block writes one 16-byte line to a synchronous external memory bus as four 32-bit beats. An internal requester presents a request with an address and the four data words. The block clears the low address bits to align the address to the line and latches everything when it accepts the request. It then drives the bus strobes, the address and the write data until the fourth beat has finished.

The beats are pipelined in a 2-1-1-1 pattern. A one-clock transfer-start cycle comes first. The first data beat follows on the next clock, and each later beat is driven on the clock after the previous beat is acknowledged. Chip select stays low for the whole line.

The termination mode is sampled when the request is accepted:

- **Internal termination.** The block acknowledges every beat itself with no wait states. The address stays line-aligned and the size code reads "line".
- **External termination.** Each beat waits for the bus acknowledge input. The address steps by one word per beat and the size code reads "longword".

The control is a three-state machine:

- `ST_IDLE` goes to `ST_START` on an accepted request.
- `ST_START` goes to `ST_XFER` unconditionally.
- `ST_XFER` stays in place across beats and wait cycles. It returns to `ST_IDLE` when the last beat is acknowledged.

Top module: `line_write_master`

## Requirements
- R1: After reset, and whenever no burst is active, the outputs are idle:
  - `req_ready`=1.
  - `bus_ts_n`, `bus_tip_n`, `bus_cs_n`, `bus_rw` and `bus_oe_n` are all 1.
  - `bus_be_n`=4'hF, `bus_siz`=2'b00, `bus_data_oe`=0.
  - `bus_addr` and `bus_data` are 0.
- R2: A request is taken at a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle through the cycle of the last beat's acknowledge. Request inputs that change while the burst runs do not alter the burst.
- R3: `bus_ts_n` is low for exactly one cycle, the cycle after acceptance. From that cycle through the cycle of the fourth beat's acknowledge, all of these hold without a break:
  - `bus_tip_n` and `bus_cs_n` are low.
  - `bus_rw` is low (0 = write).
  - `bus_be_n` is 4'h0.
- R4: Beat k (k=0..3) drives word k, which is `req_data[32k+31:32k]`, with `bus_data_oe`=1. Beat 0 starts the cycle after transfer-start. Beat k+1 starts the cycle after beat k is acknowledged. Without wait states the line takes exactly five busy cycles (2-1-1-1).
- R5: With internal termination (`ext_term`=0 at acceptance), the following hold:
  - `bus_addr` is the request address with bits [3:0] cleared, in every busy cycle.
  - `bus_siz` is 2'b11.
  - Every beat completes in one cycle whatever `bus_ta_n` does.
- R6: With external termination (`ext_term`=1 at acceptance), `bus_siz` is 2'b00 in every busy cycle. `bus_addr` is the aligned line address during transfer-start and the aligned address plus 4k during beat k.
- R7: With external termination, a beat completes only in a cycle where `bus_ta_n` is 0. Until then it repeats with the same data and address.
- R8: `done` is high for exactly one cycle, the cycle in which the fourth beat is acknowledged. `bus_tip_n` is high in the following cycle.
- R9: `bus_oe_n` stays 1 in every cycle, busy or idle.
- R10: The termination mode is fixed at acceptance; a change of `ext_term` during a burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_term | input | 1 | Termination mode for the next request: 1 = external acknowledge, 0 = internal |
| req_valid | input | 1 | Line write request present |
| req_addr | input | 32 | Request byte address (low 4 bits ignored) |
| req_data | input | 128 | Four data words, word k in bits [32k+31:32k] |
| req_ready | output | 1 | Block can accept a request |
| done | output | 1 | One-cycle pulse when the line completes |
| bus_addr | output | 32 | Bus address |
| bus_data | output | 32 | Bus write data |
| bus_data_oe | output | 1 | Write data valid / data bus drive enable |
| bus_ts_n | output | 1 | Transfer start, active low |
| bus_tip_n | output | 1 | Transfer in progress, active low |
| bus_rw | output | 1 | Read/write, 0 = write |
| bus_siz | output | 2 | Size code: 2'b11 line, 2'b00 longword |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_be_n | output | 4 | Byte selects, active low |
| bus_oe_n | output | 1 | Output enable, active low (always inactive) |
| bus_ta_n | input | 1 | External transfer acknowledge, active low |

## Verification
The hardest case to reach is a beat that is held by a missing acknowledge while the next beat's address and data stay queued behind it. Making it visible also needs a mode input and request inputs that change while the burst is held. The stimulus is a set of external-mode bursts with a different number of withheld acknowledges before each beat, including waits on the first and last beats. In some bursts `ext_term` is toggled and `req_valid` is left high with new data right after acceptance. Each cycle's bus state must then still match the latched request and the latched mode.

// File: rtl/lwm_pkg.sv
package lwm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_XFER  = 2'd2
    } lwm_state_e;

    localparam logic [1:0] SIZ_LONG = 2'b00;
    localparam logic [1:0] SIZ_LINE = 2'b11;

endpackage

// File: rtl/lwm_beat_seq.sv
module lwm_beat_seq #(
    parameter int BEATS = 4,
    parameter int IDX_W = $clog2(BEATS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [IDX_W-1:0] idx,
    output logic             last
);

    assign last = (idx == IDX_W'(BEATS - 1));

    // Wraps to zero after the last beat so every line starts at beat 0.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (adv) begin
            idx <= last ? '0 : idx + 1'b1;
        end
    end

endmodule

// File: rtl/lwm_fsm.sv
module lwm_fsm
    import lwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic ack,
    input  logic last,
    output logic busy,
    output logic ts,
    output logic data_phase,
    output logic ready
);

    lwm_state_e state_q;
    lwm_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_START;
            ST_START: state_d = ST_XFER;
            ST_XFER:  if (ack && last) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy       = 1'b0;
        ts         = 1'b0;
        data_phase = 1'b0;
        ready      = 1'b0;
        unique case (state_q)
            ST_IDLE:  ready = 1'b1;
            ST_START: begin
                busy = 1'b1;
                ts   = 1'b1;
            end
            ST_XFER: begin
                busy       = 1'b1;
                data_phase = 1'b1;
            end
            default:  ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/line_write_master.sv
module line_write_master
    import lwm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BEATS  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ext_term,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [BEATS*DATA_W-1:0] req_data,
    output logic                    req_ready,
    output logic                    done,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic [DATA_W-1:0]       bus_data,
    output logic                    bus_data_oe,
    output logic                    bus_ts_n,
    output logic                    bus_tip_n,
    output logic                    bus_rw,
    output logic [1:0]              bus_siz,
    output logic                    bus_cs_n,
    output logic [DATA_W/8-1:0]     bus_be_n,
    output logic                    bus_oe_n,
    input  logic                    bus_ta_n
);

    localparam int BE_W    = DATA_W / 8;
    localparam int BYTE_SH = $clog2(BE_W);
    localparam int LINE_B  = BEATS * BE_W;
    localparam int IDX_W   = $clog2(BEATS);
    localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(LINE_B - 1);

    logic              accept;
    logic              ack;
    logic              busy;
    logic              ts;
    logic              data_phase;
    logic              last;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] base_q;
    logic              ext_q;
    logic [DATA_W-1:0] words_q [BEATS];
    logic [ADDR_W-1:0] beat_off;

    assign accept = req_valid && req_ready;
    // Internal mode never waits; external mode waits for the bus acknowledge.
    assign ack    = ext_q ? !bus_ta_n : 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            ext_q  <= 1'b0;
            for (int i = 0; i < BEATS; i++) begin
                words_q[i] <= '0;
            end
        end else if (accept) begin
            base_q <= req_addr & ~OFF_MASK;
            ext_q  <= ext_term;
            for (int i = 0; i < BEATS; i++) begin
                words_q[i] <= req_data[i*DATA_W +: DATA_W];
            end
        end
    end

    lwm_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .ack        (ack),
        .last       (last),
        .busy       (busy),
        .ts         (ts),
        .data_phase (data_phase),
        .ready      (req_ready)
    );

    lwm_beat_seq #(
        .BEATS (BEATS),
        .IDX_W (IDX_W)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (data_phase && ack),
        .idx   (idx),
        .last  (last)
    );

    assign beat_off = ADDR_W'(idx) << BYTE_SH;

    always_comb begin
        bus_addr = '0;
        bus_siz  = SIZ_LONG;
        if (busy) begin
            bus_addr = ext_q ? (base_q | beat_off) : base_q;
            bus_siz  = ext_q ? SIZ_LONG : SIZ_LINE;
        end
    end

    assign bus_data    = data_phase ? words_q[idx] : '0;
    assign bus_data_oe = data_phase;
    assign bus_ts_n    = !ts;
    assign bus_tip_n   = !busy;
    assign bus_cs_n    = !busy;
    assign bus_rw      = !busy;
    assign bus_be_n    = {BE_W{!busy}};
    assign bus_oe_n    = 1'b1;
    assign done        = data_phase && ack && last;

endmodule

// File: rtl/lwm_checker.sv
module lwm_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BEATS  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              done,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_data,
    input logic              bus_data_oe,
    input logic              bus_ts_n,
    input logic              bus_tip_n,
    input logic [1:0]        bus_siz,
    input logic              bus_ta_n
);

    localparam int BE_W   = DATA_W / 8;
    localparam int LINE_B = BEATS * BE_W;

    assert_ts_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ts_n |=> bus_ts_n);

    assert_tip_starts_with_ts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_tip_n) |-> !bus_ts_n);

    assert_ready_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_tip_n |-> !req_ready);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && bus_tip_n));

    assert_int_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_tip_n && bus_siz == 2'b11) |-> ((bus_addr & ADDR_W'(LINE_B - 1)) == '0));

    assert_int_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_tip_n && bus_siz == 2'b11 && !done) |=> $stable(bus_addr));

    assert_ext_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_data_oe && bus_siz == 2'b00 && !bus_ta_n && !done)
            |=> bus_addr == $past(bus_addr) + ADDR_W'(BE_W));

    assert_wait_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_data_oe && bus_siz == 2'b00 && bus_ta_n)
            |=> ($stable(bus_data) && $stable(bus_addr) && bus_data_oe));

endmodule

bind line_write_master lwm_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BEATS  (BEATS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .done        (done),
    .bus_addr    (bus_addr),
    .bus_data    (bus_data),
    .bus_data_oe (bus_data_oe),
    .bus_ts_n    (bus_ts_n),
    .bus_tip_n   (bus_tip_n),
    .bus_siz     (bus_siz),
    .bus_ta_n    (bus_ta_n)
);

// File: tb/line_write_master_test.sv
`timescale 1ns/1ps
module line_write_master_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ext_term = 1'b0;
    logic         req_valid = 1'b0;
    logic [31:0]  req_addr = '0;
    logic [127:0] req_data = '0;
    logic         req_ready;
    logic         done;
    logic [31:0]  bus_addr;
    logic [31:0]  bus_data;
    logic         bus_data_oe;
    logic         bus_ts_n;
    logic         bus_tip_n;
    logic         bus_rw;
    logic [1:0]   bus_siz;
    logic         bus_cs_n;
    logic [3:0]   bus_be_n;
    logic         bus_oe_n;
    logic         bus_ta_n = 1'b1;

    int nchecks = 0;
    int nerrs   = 0;

    always #2.5 clk = ~clk;

    line_write_master uut (
        .clk (clk), .rst_n (rst_n), .ext_term (ext_term),
        .req_valid (req_valid), .req_addr (req_addr), .req_data (req_data),
        .req_ready (req_ready), .done (done), .bus_addr (bus_addr),
        .bus_data (bus_data), .bus_data_oe (bus_data_oe), .bus_ts_n (bus_ts_n),
        .bus_tip_n (bus_tip_n), .bus_rw (bus_rw), .bus_siz (bus_siz),
        .bus_cs_n (bus_cs_n), .bus_be_n (bus_be_n), .bus_oe_n (bus_oe_n),
        .bus_ta_n (bus_ta_n)
    );

    typedef struct {
        logic        ts_n, tip_n, cs_n, rw, oe_n, doe, done, ready;
        logic [1:0]  siz;
        logic [3:0]  be_n;
        logic [31:0] addr, data;
        int          mtag, dtag;
    } exp_t;

    exp_t sbq[$];

    function automatic string tag(input int n);
        case (n)
            1:  return "R1";
            4:  return "R4";
            5:  return "R5";
            6:  return "R6";
            7:  return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input bit ok, input string t, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (!ok) begin
            nerrs++;
            $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
        end
    endtask

    // Monitor: compares each cycle's outputs against the next expected item.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (sbq.size() > 0) begin
                e = sbq.pop_front();
                chk(bus_ts_n === e.ts_n, "R3", "ts_n", 32'(bus_ts_n), 32'(e.ts_n));
                chk(bus_tip_n === e.tip_n, e.tip_n ? "R8" : "R3", "tip_n", 32'(bus_tip_n), 32'(e.tip_n));
                chk(bus_cs_n === e.cs_n, "R3", "cs_n", 32'(bus_cs_n), 32'(e.cs_n));
                chk(bus_rw === e.rw, "R3", "rw", 32'(bus_rw), 32'(e.rw));
                chk(bus_be_n === e.be_n, "R3", "be_n", 32'(bus_be_n), 32'(e.be_n));
                chk(bus_oe_n === e.oe_n, "R9", "oe_n", 32'(bus_oe_n), 32'(e.oe_n));
                chk(req_ready === e.ready, "R2", "ready", 32'(req_ready), 32'(e.ready));
                chk(done === e.done, "R8", "done", 32'(done), 32'(e.done));
                chk(bus_siz === e.siz, tag(e.mtag), "siz", 32'(bus_siz), 32'(e.siz));
                chk(bus_addr === e.addr, tag(e.mtag), "addr", bus_addr, e.addr);
                chk(bus_data_oe === e.doe, tag(e.dtag), "data_oe", 32'(bus_data_oe), 32'(e.doe));
                chk(bus_data === e.data, tag(e.dtag), "data", bus_data, e.data);
            end
        end
    end

    task automatic push(input bit busy, input bit ts, input bit doe, input bit dn,
                        input logic [31:0] a, input logic [31:0] d,
                        input logic [1:0] s, input int mt, input int dt);
        exp_t e;
        e.ts_n = ~ts;   e.tip_n = ~busy; e.cs_n = ~busy; e.rw = ~busy;
        e.oe_n = 1'b1;  e.doe = doe;     e.done = dn;    e.ready = ~busy;
        e.siz = s;      e.be_n = busy ? 4'h0 : 4'hF;
        e.addr = a;     e.data = d;      e.mtag = mt;    e.dtag = dt;
        sbq.push_back(e);
    endtask

    // Driver: issues one line write and queues the expected bus cycle by cycle.
    task automatic run_burst(input bit ext, input logic [31:0] a, input logic [127:0] d,
                             input int w0, input int w1, input int w2, input int w3,
                             input bit flip, input bit hold);
        int w[4];
        logic [31:0] base;
        logic [31:0] ad;
        logic [1:0]  s;
        int mt, dt;
        w    = '{w0, w1, w2, w3};
        base = a & 32'hFFFF_FFF0;
        s    = ext ? 2'b00 : 2'b11;
        mt   = flip ? 10 : (ext ? 6 : 5);
        dt   = (ext && (w0 + w1 + w2 + w3) > 0) ? 7 : 4;
        @(posedge clk); #1;
        ext_term = ext; req_addr = a; req_data = d; req_valid = 1'b1; bus_ta_n = 1'b1;
        chk(req_ready === 1'b1, "R2", "ready before request", 32'(req_ready), 32'd1);
        @(posedge clk); #1;
        if (hold) begin
            req_addr = ~a; req_data = ~d;   // R2: request inputs change while busy
        end else begin
            req_valid = 1'b0;
        end
        if (flip) ext_term = ~ext;          // R10: mode input toggled mid-burst
        push(1, 1, 0, 0, base, 32'h0, s, mt, dt);
        for (int k = 0; k < 4; k++) begin
            ad = ext ? base + 32'(4 * k) : base;
            for (int j = 0; j < w[k]; j++) begin
                @(posedge clk); #1;
                bus_ta_n = 1'b1;             // R7: acknowledge withheld
                push(1, 0, 1, 0, ad, d[32*k +: 32], s, mt, 7);
            end
            @(posedge clk); #1;
            bus_ta_n = ext ? 1'b0 : 1'b1;    // R5: internal mode ignores bus_ta_n
            push(1, 0, 1, k == 3, ad, d[32*k +: 32], s, mt, dt);
        end
        @(posedge clk); #1;
        bus_ta_n = 1'b1; req_valid = 1'b0;
        push(0, 0, 0, 0, 32'h0, 32'h0, 2'b00, 1, 1);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        nerrs++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", nchecks, nerrs);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1, "R1", "reset ready", 32'(req_ready), 32'd1);
        chk(bus_ts_n === 1'b1 && bus_tip_n === 1'b1 && bus_cs_n === 1'b1, "R1",
            "reset strobes", {29'd0, bus_ts_n, bus_tip_n, bus_cs_n}, 32'd7);
        chk(bus_rw === 1'b1 && bus_oe_n === 1'b1 && bus_be_n === 4'hF, "R1",
            "reset rw/oe/be", {26'd0, bus_rw, bus_oe_n, bus_be_n}, 32'h3F);
        chk(bus_data_oe === 1'b0 && done === 1'b0, "R1", "reset data_oe/done",
            {30'd0, bus_data_oe, done}, 32'd0);
        chk(bus_addr === 32'h0 && bus_siz === 2'b00, "R1", "reset addr", bus_addr, 32'h0);

        // R4/R5: internal termination, 2-1-1-1, unaligned request address
        run_burst(1'b0, 32'h1000_0024, 128'h4444_4444_3333_3333_2222_2222_1111_1111,
                  0, 0, 0, 0, 1'b0, 1'b0);
        // R6: external termination, zero waits
        run_burst(1'b1, 32'h2000_0040, 128'hDDDD_0003_CCCC_0002_BBBB_0001_AAAA_0000,
                  0, 0, 0, 0, 1'b0, 1'b0);
        // R7: external with wait cycles on first and last beats
        run_burst(1'b1, 32'hABCD_EF5C, 128'h0F0F_0F0F_F0F0_F0F0_1234_5678_9ABC_DEF0,
                  2, 0, 1, 3, 1'b0, 1'b0);
        // R2/R10: internal, mode toggled and request held with new data
        run_burst(1'b0, 32'h0000_1230, 128'hCAFE_0004_BEEF_0003_FACE_0002_D00D_0001,
                  0, 0, 0, 0, 1'b1, 1'b1);
        // R10: external, mode toggled off mid-burst, with waits
        run_burst(1'b1, 32'hFFFF_FFF8, 128'h8765_4321_0BAD_F00D_5A5A_A5A5_0000_FFFF,
                  1, 1, 0, 0, 1'b1, 1'b0);
        // R1: idle again after the last burst
        @(negedge clk);
        chk(req_ready === 1'b1 && bus_tip_n === 1'b1, "R1", "final idle",
            {30'd0, req_ready, bus_tip_n}, 32'd3);

        $display("CHECKS %0d ERRORS %0d", nchecks, nerrs);
        $finish;
    end

endmodule